// File: doc/BRIEF.md
# Rate-Adjustable Precision Time Counter

This block keeps a 64-bit running time value for a precision time protocol clock. One unit of the count stands for 8 ns. The advance rate is trimmed by a 32-bit rate word fed into a fractional accumulator. At the nominal rate word the count moves by exactly one per cycle. Larger words make it move faster and smaller words make it move slower, over a usable span of roughly 0.968x to 1.032x.

A host-side register agent drives three write ports: a command word, a 64-bit time value and a rate word. It reads the time through a snapshot request. Each command word must carry a valid flag. A command word can do four things: clear the clock, choose a sticky write mode, set a sticky timestamp-correction flag, and fire one-cycle strobes that neighbouring schedule and pin-output logic decodes. In set mode a time value write replaces the count. In add mode the written value is a signed step added to the running count.

All ports are plain control pins. Every write is taken in the cycle it is presented, so there is no back-pressure. A snapshot request is always answered exactly one cycle later.

Top module: `ptp_rate_clock`

## Requirements
- R1: After reset: `time_now` is 0, `rd_valid` is 0, `rd_data` is 0, `cmd_strobe` is 0, `corr_ts` is 0, the rate word is 0x80000000 and the write mode is set mode.
- R2: With the rate word at 0x80000000 and no writes, `time_now` grows by exactly 1 every cycle and wraps from all-ones to 0.
- R3: Each cycle the rate word is added to a 31-bit fraction. The count grows by the integer part of that sum (bits 32:31, range 0..2) and the low 31 bits are carried forward. A rate write takes effect from the following cycle.
- R4: In set mode a `val_wr` makes `time_now` equal to `val_data` after the next edge, and the tick of that cycle is dropped.
- R5: In add mode a `val_wr` makes `time_now` equal to old time + `val_data` (two's complement, modulo 2^64) + the tick of that cycle.
- R6: A command write with bit 31 (valid) and bit 2 (clear) both set makes `time_now` 0 after the next edge and empties the fraction. The rate word keeps its value.
- R7: Bit 0 of an accepted command selects the mode (1 = add, 0 = set) and holds until the next accepted command. A `val_wr` in the same cycle as a mode change still uses the old mode.
- R8: A command write with bit 31 clear changes nothing: no strobe, no mode change, no flag change, no clear.
- R9: An accepted command raises `cmd_strobe` for exactly the one cycle after the write. The mapping is `cmd_strobe[3]` = bit 30 (schedule start), [2] = bit 29 (schedule stop), [1] = bit 28 (pin output start) and [0] = bit 27 (pin output stop). Bit 1 is stored as the sticky level `corr_ts`.
- R10: `rd_req` causes `rd_valid` = 1 in the next cycle, with `rd_data` holding all 64 bits of `time_now` as they were in the request cycle. Otherwise `rd_valid` is 0 and `rd_data` holds its value.
- R11: A clear command and a `val_wr` in the same cycle leave `time_now` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word |
| val_wr | input | 1 | Time value write strobe |
| val_data | input | 64 | Time value or signed step |
| rate_wr | input | 1 | Rate word write strobe |
| rate_data | input | 32 | Rate word, 0x80000000 nominal |
| rd_req | input | 1 | Snapshot request |
| rd_valid | output | 1 | Snapshot ready, one cycle after request |
| rd_data | output | 64 | Snapshot of the time value |
| time_now | output | 64 | Live time value |
| cmd_strobe | output | 4 | One-cycle command strobes |
| corr_ts | output | 1 | Sticky timestamp-correction flag |

## Verification
A corrupted fraction or rate register shows up at `time_now` within a few cycles. The step pattern drifts from the 1/2 or 1/0 sequence the rate implies, so a cycle-by-cycle comparison against a bench model catches it one edge after the divergence. A wrong sticky mode bit stays invisible until the next value write, and then it puts a set-versus-add difference on `time_now` at the very next edge. The bench therefore follows every mode change with value writes. Snapshot defects show on `rd_data` one cycle after each request.

// File: rtl/ptpclk_pkg.sv
package ptpclk_pkg;
  localparam int unsigned CMD_W          = 32;
  localparam int unsigned CMD_VALID      = 31;
  localparam int unsigned CMD_STROBE_LSB = 27;
  localparam int unsigned N_STROBE       = 4;
  localparam int unsigned CMD_CLEAR      = 2;
  localparam int unsigned CMD_CORR       = 1;
  localparam int unsigned CMD_ADD        = 0;
  localparam int unsigned STEP_W         = 2;

  typedef enum logic {MODE_SET = 1'b0, MODE_ADD = 1'b1} wr_mode_e;
endpackage

// File: rtl/ptpclk_cmd_dec.sv
module ptpclk_cmd_dec
  import ptpclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [CMD_W-1:0]    cmd_data,
  output wr_mode_e            mode,
  output logic                corr_ts,
  output logic [N_STROBE-1:0] strobe,
  output logic                clear_req
);
  logic accept;
  logic unused_cmd;

  assign accept     = cmd_wr & cmd_data[CMD_VALID];
  assign clear_req  = accept & cmd_data[CMD_CLEAR];
  assign unused_cmd = ^cmd_data[CMD_STROBE_LSB-1:CMD_CLEAR+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_SET;
      corr_ts <= 1'b0;
    end else if (accept) begin
      mode    <= cmd_data[CMD_ADD] ? MODE_ADD : MODE_SET;
      corr_ts <= cmd_data[CMD_CORR];
    end
  end

  for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe[g] <= 1'b0;
      else        strobe[g] <= accept & cmd_data[CMD_STROBE_LSB+g];
    end
  end
endmodule

// File: rtl/ptpclk_rate_acc.sv
module ptpclk_rate_acc
  import ptpclk_pkg::*;
#(
  parameter int unsigned RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_data,
  input  logic              clr,
  output logic [STEP_W-1:0] step
);
  localparam int unsigned FRAC_W = RATE_W - 1;
  localparam logic [RATE_W-1:0] RATE_NOM = RATE_W'(1) << FRAC_W;

  logic [RATE_W-1:0] rate_q;
  logic [FRAC_W-1:0] frac_q;
  logic [RATE_W:0]   sum;

  assign sum  = {2'b00, frac_q} + {1'b0, rate_q};
  assign step = sum[RATE_W:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate_q <= RATE_NOM;
    else if (rate_wr) rate_q <= rate_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   frac_q <= '0;
    else if (clr) frac_q <= '0;
    else          frac_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/ptpclk_time_cnt.sv
module ptpclk_time_cnt
  import ptpclk_pkg::*;
#(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  wr_mode_e          mode,
  input  logic [TIME_W-1:0] val,
  input  logic [STEP_W-1:0] step,
  output logic [TIME_W-1:0] time_q
);
  logic [TIME_W-1:0] ticked;
  logic [TIME_W-1:0] nxt;

  assign ticked = time_q + TIME_W'(step);

  always_comb begin
    if (clr)                          nxt = '0;
    else if (load && mode == MODE_ADD) nxt = ticked + val;
    else if (load)                    nxt = val;
    else                              nxt = ticked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= nxt;
  end
endmodule

// File: rtl/ptp_rate_clock.sv
module ptp_rate_clock
  import ptpclk_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned RATE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [CMD_W-1:0]    cmd_data,
  input  logic                val_wr,
  input  logic [TIME_W-1:0]   val_data,
  input  logic                rate_wr,
  input  logic [RATE_W-1:0]   rate_data,
  input  logic                rd_req,
  output logic                rd_valid,
  output logic [TIME_W-1:0]   rd_data,
  output logic [TIME_W-1:0]   time_now,
  output logic [N_STROBE-1:0] cmd_strobe,
  output logic                corr_ts
);
  wr_mode_e          mode;
  logic              clear_req;
  logic [STEP_W-1:0] step;

  ptpclk_cmd_dec i_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .mode(mode), .corr_ts(corr_ts), .strobe(cmd_strobe), .clear_req(clear_req)
  );

  ptpclk_rate_acc #(.RATE_W(RATE_W)) i_rate (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_data(rate_data),
    .clr(clear_req), .step(step)
  );

  ptpclk_time_cnt #(.TIME_W(TIME_W)) i_time (
    .clk(clk), .rst_n(rst_n), .clr(clear_req), .load(val_wr), .mode(mode),
    .val(val_data), .step(step), .time_q(time_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= time_now;
    end
  end
endmodule

// File: rtl/ptp_rate_clock_chk.sv
module ptp_rate_clock_chk
  import ptpclk_pkg::*;
#(
  parameter int unsigned TIME_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_wr,
  input logic [CMD_W-1:0]    cmd_data,
  input logic                val_wr,
  input logic [TIME_W-1:0]   val_data,
  input logic                rd_req,
  input logic                rd_valid,
  input logic [TIME_W-1:0]   rd_data,
  input logic [TIME_W-1:0]   time_now,
  input logic [N_STROBE-1:0] cmd_strobe,
  input logic                corr_ts,
  input wr_mode_e            mode
);
  logic clr_cmd;
  assign clr_cmd = cmd_wr && cmd_data[CMD_VALID] && cmd_data[CMD_CLEAR];

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cmd_wr && !val_wr) |-> (time_now - $past(time_now)) <= TIME_W'(2)); // R3

  AST_SET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(val_wr && mode == MODE_SET && !clr_cmd) |-> time_now == $past(val_data)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_cmd) |-> time_now == '0); // R6

  AST_CLEAR_BEATS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_cmd && val_wr) |-> time_now == '0); // R11

  AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr && !cmd_data[CMD_VALID]) |-> cmd_strobe == '0 && $stable(corr_ts)); // R8

  AST_STROBE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr && cmd_data[CMD_VALID] && cmd_data[CMD_STROBE_LSB+3]) |-> cmd_strobe[3]); // R9

  AST_READ_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_req) |-> rd_valid && rd_data == $past(time_now)); // R10
endmodule

bind ptp_rate_clock ptp_rate_clock_chk #(.TIME_W(TIME_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
  .val_wr(val_wr), .val_data(val_data), .rd_req(rd_req), .rd_valid(rd_valid),
  .rd_data(rd_data), .time_now(time_now), .cmd_strobe(cmd_strobe),
  .corr_ts(corr_ts), .mode(mode)
);

// File: tb/test_ptp_rate_clock.sv
module test_ptp_rate_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        val_wr = 1'b0;
  logic [63:0] val_data = '0;
  logic        rate_wr = 1'b0;
  logic [31:0] rate_data = '0;
  logic        rd_req = 1'b0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [63:0] time_now;
  logic [3:0]  cmd_strobe;
  logic        corr_ts;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m_time = '0;
  logic [30:0] m_frac = '0;
  logic [31:0] m_rate = 32'h8000_0000;
  logic        m_add = 1'b0;
  logic        m_corr = 1'b0;
  logic [3:0]  m_strobe = '0;
  logic        m_rdv = 1'b0;
  logic [63:0] m_rdd = '0;

  always #2 clk = ~clk;

  ptp_rate_clock i_ptp_rate_clock (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .val_wr(val_wr), .val_data(val_data), .rate_wr(rate_wr), .rate_data(rate_data),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .time_now(time_now),
    .cmd_strobe(cmd_strobe), .corr_ts(corr_ts)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "time_now", time_now, m_time);
    check("R10", "rd_valid", 64'(rd_valid), 64'(m_rdv));
    check("R10", "rd_data", rd_data, m_rdd);
    check("R9", "cmd_strobe", 64'(cmd_strobe), 64'(m_strobe));
    check("R9", "corr_ts", 64'(corr_ts), 64'(m_corr));
  endtask

  // Next state from the requirements (R3 step, R4/R5 writes, R6/R11 clear, R7-R10)
  task automatic model_step();
    logic [32:0] sum;
    logic [63:0] stp;
    logic        acc;
    sum = {2'b00, m_frac} + {1'b0, m_rate};
    stp = 64'(sum[32:31]);
    acc = cmd_wr && cmd_data[31];
    m_rdv = rd_req;
    if (rd_req) m_rdd = m_time;
    if (acc && cmd_data[2]) begin
      m_time = '0;
      m_frac = '0;
    end else begin
      m_frac = sum[30:0];
      if (val_wr && m_add) m_time = m_time + stp + val_data;
      else if (val_wr)     m_time = val_data;
      else                 m_time = m_time + stp;
    end
    m_strobe = acc ? cmd_data[30:27] : 4'b0;
    if (acc) begin
      m_add  = cmd_data[0];
      m_corr = cmd_data[1];
    end
    if (rate_wr) m_rate = rate_data;
  endtask

  task automatic cycle(input logic cw, input logic [31:0] cd, input logic vw,
                       input logic [63:0] vd, input logic rw, input logic [31:0] rd,
                       input logic rr, input string tag);
    cmd_wr = cw; cmd_data = cd; val_wr = vw; val_data = vd;
    rate_wr = rw; rate_data = rd; rd_req = rr;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(0, '0, 0, '0, 0, '0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    idle(4, "R2");
    cycle(0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFC, 0, '0, 0, "R4");
    idle(8, "R2");                                   // wraps through zero
    cycle(0, '0, 0, '0, 0, '0, 1, "R10");
    cycle(1, 32'h8000_0001, 0, '0, 0, '0, 0, "R7");
    cycle(0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFB, 0, '0, 0, "R5");
    cycle(0, '0, 1, 64'd1000, 0, '0, 1, "R5");
    cycle(1, 32'h0000_0000, 0, '0, 0, '0, 0, "R8");
    cycle(0, '0, 1, 64'd77, 0, '0, 0, "R8");          // still add mode
    cycle(1, 32'h7800_0006, 0, '0, 0, '0, 0, "R8");   // no valid bit: no clear
    cycle(1, 32'h8000_0000, 1, 64'd50, 0, '0, 0, "R7"); // old (add) mode applies
    cycle(0, '0, 1, 64'h1234_5678_9ABC_DEF0, 0, '0, 0, "R4");
    cycle(1, 32'h8000_0005, 1, 64'd999, 0, '0, 0, "R11");
    idle(2, "R6");
    cycle(0, '0, 0, '0, 1, 32'hC000_0000, 0, "R3");
    idle(8, "R3");
    cycle(1, 32'h8000_0004, 0, '0, 0, '0, 0, "R6");
    cycle(0, '0, 0, '0, 1, 32'h7C00_0000, 1, "R3");
    idle(12, "R3");
    cycle(0, '0, 0, '0, 1, 32'h8000_0000, 0, "R3");
    cycle(1, 32'hF800_0002, 0, '0, 0, '0, 0, "R9");
    idle(2, "R9");
    cycle(1, 32'h9000_0000, 0, '0, 0, '0, 1, "R9");
    cycle(0, '0, 0, '0, 0, '0, 1, "R10");
    idle(3, "R2");
    for (int i = 0; i < 3000; i++) begin
      logic        cw, vw, rw, rr;
      logic [31:0] cd, rd;
      logic [63:0] vd;
      string       tag;
      cw = ($urandom % 100) < 8;
      cd = $urandom;
      if (($urandom % 8) != 0) cd[31] = 1'b1;
      if (($urandom % 6) != 0) cd[2] = 1'b0;
      vw = ($urandom % 100) < 10;
      vd = {$urandom, $urandom};
      if ($urandom % 2) vd = 64'($signed($urandom % 4096) - 2048);
      rw = ($urandom % 100) < 5;
      rd = 32'h7C00_0000 + ($urandom % 32'h0800_0001);
      rr = ($urandom % 100) < 15;
      tag = "R3";
      if (cw && cd[31] && cd[2]) tag = "R6";
      else if (vw)               tag = m_add ? "R5" : "R4";
      else if (cw)               tag = "R7";
      cycle(cw, cd, vw, vd, rw, rd, rr, tag);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule